// File: doc/BRIEF.md
# AXI Address Router with Upper-Alias Rewrite

This block sits behind one AXI4 slave port. It decodes the read and write address requests. Each request is sent to one of three places: a pass-through bridge port, a memory-controller port, or an internal responder that completes the burst with DECERR. The decision depends on the 40-bit address and on a boot-mode input.

The memory span covers 8 GiB and is cut into eight 1-GiB sections. These sections are not in alphabetical order. Two low 1-GiB windows are mirrors of sections a and b. Requests to those windows are moved to the upper copy before they go to the memory controller. Along with each memory-controller request the block gives a 3-bit section index and a flag for programmable versus fixed interleave. Each address channel keeps a single registered slot. A request is accepted, held one cycle later on the chosen output, and kept there until that port takes it. For reserved space, the internal responder sends the read beats itself, or takes in the write beats and sends one write response.

Top module: `axiAliasRouter`

## Requirements
- R1: An address at or above 0x04_0000_0000 is reserved. A read there ends with DECERR beats. A write there ends with a DECERR write response. Nothing is sent to the bridge or memory port.
- R2: An address from 0x01_0000_0000 to 0x01_FFFF_FFFF is reserved and is completed with DECERR in the same way as R1.
- R3: An address from 0x00_0000_0000 to 0x00_000F_FFFF goes to the memory port unchanged when `bootToMem` is 1. It goes to the bridge port when `bootToMem` is 0. A memory-port boot access reports section index 0 and the fixed-interleave flag (0).
- R4: An address from 0x00_0010_0000 to 0x00_7FFF_FFFF goes to the bridge port. The address, ID, length, size, burst and protection are passed unchanged. The output valid rises in the cycle after the request is accepted.
- R5: An address from 0x00_8000_0000 to 0x00_FFFF_FFFF goes to the memory port with 0x02_0000_0000 added to it. Every address on the memory port is either a boot address or lies in 0x02_0000_0000 to 0x03_FFFF_FFFF.
- R6: Addresses from 0x02_0000_0000 to 0x03_FFFF_FFFF go unchanged to the memory port. Their section index is chosen by the 1-GiB slot counted from 0x02_0000_0000. Slots 0 to 7 hold sections c, d, a, b, g, h, e, f in that order. The index is encoded a=0, b=1, …, h=7.
- R7: The interleave flag is 1 for sections a and b, including their low mirrors, and 0 for the other six sections.
- R8: A reserved read returns length+1 beats. Each beat carries response code 2'b11 and the request's ID. The last flag is set on the final beat only.
- R9: A reserved write drains write beats, with write-ready high, until a beat carries the last flag. It then issues exactly one response with code 2'b11 and the request's ID.
- R10: Each channel holds at most one request. Its ready is low from the acceptance until the request has been taken by its port or its DECERR completion has finished. At most one of that channel's output valids is high at any time.
- R11: While a forwarded request waits for its port's ready, the valid and all payload fields stay unchanged.
- R12: While reset is asserted, both address readies are high and every output valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootToMem | input | 1 | Boot mode: 1 sends the boot window to the memory port |
| sArValid | input | 1 | Read address valid |
| sArReady | output | 1 | Read address ready |
| sArAddr | input | 40 | Read address |
| sArId | input | ID_W | Read ID |
| sArLen | input | LEN_W | Read burst length minus one |
| sArSize | input | 3 | Read beat size |
| sArBurst | input | 2 | Read burst type |
| sArProt | input | 3 | Read protection |
| sAwValid | input | 1 | Write address valid |
| sAwReady | output | 1 | Write address ready |
| sAwAddr | input | 40 | Write address |
| sAwId | input | ID_W | Write ID |
| sAwLen | input | LEN_W | Write burst length minus one |
| sAwSize | input | 3 | Write beat size |
| sAwBurst | input | 2 | Write burst type |
| sAwProt | input | 3 | Write protection |
| arBrValid | output | 1 | Read request valid toward the bridge |
| arBrReady | input | 1 | Bridge accepts the read request |
| arMcValid | output | 1 | Read request valid toward the memory controller |
| arMcReady | input | 1 | Memory controller accepts the read request |
| arOutAddr | output | 40 | Forwarded read address (rewritten for mirrors) |
| arOutId | output | ID_W | Forwarded read ID |
| arOutLen | output | LEN_W | Forwarded read length |
| arOutSize | output | 3 | Forwarded read size |
| arOutBurst | output | 2 | Forwarded read burst |
| arOutProt | output | 3 | Forwarded read protection |
| arOutSection | output | 3 | Read section index (memory route only) |
| arOutProgIlv | output | 1 | Read programmable-interleave flag |
| awBrValid | output | 1 | Write request valid toward the bridge |
| awBrReady | input | 1 | Bridge accepts the write request |
| awMcValid | output | 1 | Write request valid toward the memory controller |
| awMcReady | input | 1 | Memory controller accepts the write request |
| awOutAddr | output | 40 | Forwarded write address (rewritten for mirrors) |
| awOutId | output | ID_W | Forwarded write ID |
| awOutLen | output | LEN_W | Forwarded write length |
| awOutSize | output | 3 | Forwarded write size |
| awOutBurst | output | 2 | Forwarded write burst |
| awOutProt | output | 3 | Forwarded write protection |
| awOutSection | output | 3 | Write section index (memory route only) |
| awOutProgIlv | output | 1 | Write programmable-interleave flag |
| errRValid | output | 1 | DECERR read beat valid |
| errRReady | input | 1 | DECERR read beat accepted |
| errRId | output | ID_W | DECERR read beat ID |
| errRResp | output | 2 | DECERR read response code |
| errRLast | output | 1 | Final DECERR read beat |
| errWValid | input | 1 | Write beat valid for a reserved write |
| errWReady | output | 1 | Write beat accepted and discarded |
| errWLast | input | 1 | Final write beat of a reserved write |
| errBValid | output | 1 | DECERR write response valid |
| errBReady | input | 1 | DECERR write response accepted |
| errBId | output | ID_W | DECERR write response ID |
| errBResp | output | 2 | DECERR write response code |

## Verification
Each channel's error path works on its own. So a DECERR read burst and a DECERR write drain can be in progress in the same cycle. In the same way, the last beat of one channel's error completion can meet a handoff on the other channel. The bench forces the first case by issuing a reserved read and a reserved write from parallel threads. The readies on every output are set at random each cycle, so the streaming of beats, the drain of write data and the handoffs overlap in different phases. The behavioural reference model follows the two channels as separate phase variables. Each cycle it checks that the read beats keep their own ID and last-beat timing while the write response appears only after its last write beat.

// File: rtl/axiAliasRouterPkg.sv
package axiAliasRouterPkg;

  localparam int ADDR_W = 40;
  localparam int SECT_W = 3;
  localparam logic [1:0] RESP_DECERR = 2'b11;
  localparam logic [ADDR_W-1:0] MIRROR_OFFSET = 40'h02_0000_0000;

  typedef enum logic [1:0] {
    ROUTE_BRIDGE = 2'd0,
    ROUTE_MEM    = 2'd1,
    ROUTE_ERR    = 2'd2
  } routeE;

  // strobes from control to the address datapath
  typedef struct packed {
    logic capture;
    logic retire;
  } pathStrobeT;

  typedef struct packed {
    routeE             route;
    logic [ADDR_W-1:0] addr;
    logic [SECT_W-1:0] section;
    logic              progIlv;
  } decodeT;

  // Address map: bit 34 and above reserved; bit 33 set is the 8-GiB memory span;
  // bit 32 alone is the hole; bit 31 is the low mirror of sections a/b.
  function automatic decodeT decodeAddr(input logic [ADDR_W-1:0] a, input logic bootToMem);
    decodeT d;
    logic [2:0] slot;
    slot      = a[32:30];
    d.route   = ROUTE_BRIDGE;
    d.addr    = a;
    d.section = '0;
    d.progIlv = 1'b0;
    if (|a[ADDR_W-1:34]) begin
      d.route = ROUTE_ERR;
    end else if (a[33]) begin
      d.route   = ROUTE_MEM;
      d.section = slot ^ 3'b010;
      d.progIlv = (slot[2:1] == 2'b01);
    end else if (a[32]) begin
      d.route = ROUTE_ERR;
    end else if (a[31]) begin
      d.route   = ROUTE_MEM;
      d.addr    = a + MIRROR_OFFSET;
      d.section = {2'b00, a[30]};
      d.progIlv = 1'b1;
    end else if (a[31:20] == 12'h000) begin
      d.route = bootToMem ? ROUTE_MEM : ROUTE_BRIDGE;
    end
    return d;
  endfunction

endpackage

// File: rtl/rtrAddrPath.sv
module rtrAddrPath
  import axiAliasRouterPkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootToMem,
  input  pathStrobeT        strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ID_W-1:0]   inId,
  input  logic [LEN_W-1:0]  inLen,
  input  logic [2:0]        inSize,
  input  logic [1:0]        inBurst,
  input  logic [2:0]        inProt,
  output routeE             inRoute,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ID_W-1:0]   outId,
  output logic [LEN_W-1:0]  outLen,
  output logic [2:0]        outSize,
  output logic [1:0]        outBurst,
  output logic [2:0]        outProt,
  output logic [SECT_W-1:0] outSection,
  output logic              outProgIlv
);

  decodeT dec;

  always_comb dec = decodeAddr(inAddr, bootToMem);
  assign inRoute = dec.route;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr    <= '0;
      outId      <= '0;
      outLen     <= '0;
      outSize    <= '0;
      outBurst   <= '0;
      outProt    <= '0;
      outSection <= '0;
      outProgIlv <= 1'b0;
    end else if (strobe.capture) begin
      outAddr    <= dec.addr;
      outId      <= inId;
      outLen     <= inLen;
      outSize    <= inSize;
      outBurst   <= inBurst;
      outProt    <= inProt;
      outSection <= dec.section;
      outProgIlv <= dec.progIlv;
    end else if (strobe.retire) begin
      outAddr    <= '0;
      outId      <= '0;
      outLen     <= '0;
      outSize    <= '0;
      outBurst   <= '0;
      outProt    <= '0;
      outSection <= '0;
      outProgIlv <= 1'b0;
    end
  end

endmodule

// File: rtl/rtrSeq.sv
module rtrSeq
  import axiAliasRouterPkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arValid,
  input  routeE            arInRoute,
  input  logic [LEN_W-1:0] arLen,
  output logic             arReady,
  output pathStrobeT       arStb,
  output logic             arBrValid,
  input  logic             arBrReady,
  output logic             arMcValid,
  input  logic             arMcReady,
  output logic             errRValid,
  input  logic             errRReady,
  output logic             errRLast,
  input  logic             awValid,
  input  routeE            awInRoute,
  output logic             awReady,
  output pathStrobeT       awStb,
  output logic             awBrValid,
  input  logic             awBrReady,
  output logic             awMcValid,
  input  logic             awMcReady,
  input  logic             errWValid,
  output logic             errWReady,
  input  logic             errWLast,
  output logic             errBValid,
  input  logic             errBReady
);

  typedef enum logic [1:0] {AR_IDLE, AR_FWD_BR, AR_FWD_MC, AR_ERR_DATA} arStE;
  typedef enum logic [2:0] {AW_IDLE, AW_FWD_BR, AW_FWD_MC, AW_ERR_DRAIN, AW_ERR_RESP} awStE;

  arStE             arState, arNext;
  awStE             awState, awNext;
  logic [LEN_W-1:0] beatsLeft;
  logic             finalBeat;

  assign finalBeat = (beatsLeft == '0);

  // read channel
  always_comb begin
    arNext = arState;
    arStb  = '0;
    unique case (arState)
      AR_IDLE: if (arValid) begin
        arStb.capture = 1'b1;
        unique case (arInRoute)
          ROUTE_BRIDGE: arNext = AR_FWD_BR;
          ROUTE_MEM:    arNext = AR_FWD_MC;
          default:      arNext = AR_ERR_DATA;
        endcase
      end
      AR_FWD_BR: if (arBrReady) begin
        arNext       = AR_IDLE;
        arStb.retire = 1'b1;
      end
      AR_FWD_MC: if (arMcReady) begin
        arNext       = AR_IDLE;
        arStb.retire = 1'b1;
      end
      AR_ERR_DATA: if (errRReady && finalBeat) begin
        arNext       = AR_IDLE;
        arStb.retire = 1'b1;
      end
      default: arNext = AR_IDLE;
    endcase
  end

  // write channel
  always_comb begin
    awNext = awState;
    awStb  = '0;
    unique case (awState)
      AW_IDLE: if (awValid) begin
        awStb.capture = 1'b1;
        unique case (awInRoute)
          ROUTE_BRIDGE: awNext = AW_FWD_BR;
          ROUTE_MEM:    awNext = AW_FWD_MC;
          default:      awNext = AW_ERR_DRAIN;
        endcase
      end
      AW_FWD_BR: if (awBrReady) begin
        awNext       = AW_IDLE;
        awStb.retire = 1'b1;
      end
      AW_FWD_MC: if (awMcReady) begin
        awNext       = AW_IDLE;
        awStb.retire = 1'b1;
      end
      AW_ERR_DRAIN: if (errWValid && errWLast) awNext = AW_ERR_RESP;
      AW_ERR_RESP: if (errBReady) begin
        awNext       = AW_IDLE;
        awStb.retire = 1'b1;
      end
      default: awNext = AW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arState   <= AR_IDLE;
      awState   <= AW_IDLE;
      beatsLeft <= '0;
    end else begin
      arState <= arNext;
      awState <= awNext;
      if (arStb.capture) beatsLeft <= arLen;
      else if (arState == AR_ERR_DATA && errRReady && !finalBeat) beatsLeft <= beatsLeft - 1'b1;
    end
  end

  assign arReady   = (arState == AR_IDLE);
  assign arBrValid = (arState == AR_FWD_BR);
  assign arMcValid = (arState == AR_FWD_MC);
  assign errRValid = (arState == AR_ERR_DATA);
  assign errRLast  = errRValid && finalBeat;

  assign awReady   = (awState == AW_IDLE);
  assign awBrValid = (awState == AW_FWD_BR);
  assign awMcValid = (awState == AW_FWD_MC);
  assign errWReady = (awState == AW_ERR_DRAIN);
  assign errBValid = (awState == AW_ERR_RESP);

endmodule

// File: rtl/axiAliasRouter.sv
module axiAliasRouter
  import axiAliasRouterPkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootToMem,
  input  logic              sArValid,
  output logic              sArReady,
  input  logic [ADDR_W-1:0] sArAddr,
  input  logic [ID_W-1:0]   sArId,
  input  logic [LEN_W-1:0]  sArLen,
  input  logic [2:0]        sArSize,
  input  logic [1:0]        sArBurst,
  input  logic [2:0]        sArProt,
  input  logic              sAwValid,
  output logic              sAwReady,
  input  logic [ADDR_W-1:0] sAwAddr,
  input  logic [ID_W-1:0]   sAwId,
  input  logic [LEN_W-1:0]  sAwLen,
  input  logic [2:0]        sAwSize,
  input  logic [1:0]        sAwBurst,
  input  logic [2:0]        sAwProt,
  output logic              arBrValid,
  input  logic              arBrReady,
  output logic              arMcValid,
  input  logic              arMcReady,
  output logic [ADDR_W-1:0] arOutAddr,
  output logic [ID_W-1:0]   arOutId,
  output logic [LEN_W-1:0]  arOutLen,
  output logic [2:0]        arOutSize,
  output logic [1:0]        arOutBurst,
  output logic [2:0]        arOutProt,
  output logic [SECT_W-1:0] arOutSection,
  output logic              arOutProgIlv,
  output logic              awBrValid,
  input  logic              awBrReady,
  output logic              awMcValid,
  input  logic              awMcReady,
  output logic [ADDR_W-1:0] awOutAddr,
  output logic [ID_W-1:0]   awOutId,
  output logic [LEN_W-1:0]  awOutLen,
  output logic [2:0]        awOutSize,
  output logic [1:0]        awOutBurst,
  output logic [2:0]        awOutProt,
  output logic [SECT_W-1:0] awOutSection,
  output logic              awOutProgIlv,
  output logic              errRValid,
  input  logic              errRReady,
  output logic [ID_W-1:0]   errRId,
  output logic [1:0]        errRResp,
  output logic              errRLast,
  input  logic              errWValid,
  output logic              errWReady,
  input  logic              errWLast,
  output logic              errBValid,
  input  logic              errBReady,
  output logic [ID_W-1:0]   errBId,
  output logic [1:0]        errBResp
);

  pathStrobeT arStb, awStb;
  routeE      arInRoute, awInRoute;

  rtrAddrPath #(.ID_W(ID_W), .LEN_W(LEN_W)) u_arPath (
    .clk(clk), .rstN(rstN), .bootToMem(bootToMem), .strobe(arStb),
    .inAddr(sArAddr), .inId(sArId), .inLen(sArLen), .inSize(sArSize),
    .inBurst(sArBurst), .inProt(sArProt), .inRoute(arInRoute),
    .outAddr(arOutAddr), .outId(arOutId), .outLen(arOutLen), .outSize(arOutSize),
    .outBurst(arOutBurst), .outProt(arOutProt), .outSection(arOutSection),
    .outProgIlv(arOutProgIlv)
  );

  rtrAddrPath #(.ID_W(ID_W), .LEN_W(LEN_W)) u_awPath (
    .clk(clk), .rstN(rstN), .bootToMem(bootToMem), .strobe(awStb),
    .inAddr(sAwAddr), .inId(sAwId), .inLen(sAwLen), .inSize(sAwSize),
    .inBurst(sAwBurst), .inProt(sAwProt), .inRoute(awInRoute),
    .outAddr(awOutAddr), .outId(awOutId), .outLen(awOutLen), .outSize(awOutSize),
    .outBurst(awOutBurst), .outProt(awOutProt), .outSection(awOutSection),
    .outProgIlv(awOutProgIlv)
  );

  rtrSeq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rstN(rstN),
    .arValid(sArValid), .arInRoute(arInRoute), .arLen(sArLen), .arReady(sArReady),
    .arStb(arStb), .arBrValid(arBrValid), .arBrReady(arBrReady),
    .arMcValid(arMcValid), .arMcReady(arMcReady),
    .errRValid(errRValid), .errRReady(errRReady), .errRLast(errRLast),
    .awValid(sAwValid), .awInRoute(awInRoute), .awReady(sAwReady),
    .awStb(awStb), .awBrValid(awBrValid), .awBrReady(awBrReady),
    .awMcValid(awMcValid), .awMcReady(awMcReady),
    .errWValid(errWValid), .errWReady(errWReady), .errWLast(errWLast),
    .errBValid(errBValid), .errBReady(errBReady)
  );

  assign errRId   = arOutId;
  assign errRResp = RESP_DECERR;
  assign errBId   = awOutId;
  assign errBResp = RESP_DECERR;

endmodule

// File: rtl/axiAliasRouterChk.sv
module axiAliasRouterChk
  import axiAliasRouterPkg::*;
#(
  parameter int ID_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sArValid,
  input logic              sArReady,
  input logic              sAwValid,
  input logic              sAwReady,
  input logic              arBrValid,
  input logic              arBrReady,
  input logic              arMcValid,
  input logic [ADDR_W-1:0] arOutAddr,
  input logic [ID_W-1:0]   arOutId,
  input logic [SECT_W-1:0] arOutSection,
  input logic              arOutProgIlv,
  input logic              awBrValid,
  input logic              awMcValid,
  input logic              awMcReady,
  input logic [ADDR_W-1:0] awOutAddr,
  input logic [ID_W-1:0]   awOutId,
  input logic              errRValid,
  input logic              errRReady,
  input logic              errRLast,
  input logic              errWValid,
  input logic              errWReady,
  input logic              errWLast,
  input logic              errBValid
);

  AST_AR_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (sArValid && sArReady) |=> !sArReady); // R10
  AST_AW_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (sAwValid && sAwReady) |=> !sAwReady); // R10
  AST_AR_ONE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arBrValid, arMcValid, errRValid})); // R10
  AST_AW_ONE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({awBrValid, awMcValid, errWReady, errBValid})); // R10
  AST_AR_FWD_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (sArValid && sArReady) |=> (arBrValid || arMcValid || errRValid)); // R4
  AST_AR_BR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (arBrValid && !arBrReady) |=> (arBrValid && $stable(arOutAddr) && $stable(arOutId))); // R11
  AST_AW_MC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (awMcValid && !awMcReady) |=> (awMcValid && $stable(awOutAddr) && $stable(awOutId))); // R11
  AST_MC_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    awMcValid |-> (awOutAddr[ADDR_W-1:34] == '0 && (awOutAddr[33] || awOutAddr[33:20] == '0))); // R5
  AST_PROG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (arMcValid && arOutAddr[33]) |-> (arOutProgIlv == (arOutSection[2:1] == 2'b00))); // R7
  AST_RLAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (errRValid && errRReady && errRLast) |=> !errRValid); // R8
  AST_B_AFTER_WLAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errBValid) |-> $past(errWValid && errWReady && errWLast)); // R9

endmodule

bind axiAliasRouter axiAliasRouterChk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .sArValid(sArValid), .sArReady(sArReady), .sAwValid(sAwValid), .sAwReady(sAwReady),
  .arBrValid(arBrValid), .arBrReady(arBrReady), .arMcValid(arMcValid),
  .arOutAddr(arOutAddr), .arOutId(arOutId), .arOutSection(arOutSection),
  .arOutProgIlv(arOutProgIlv),
  .awBrValid(awBrValid), .awMcValid(awMcValid), .awMcReady(awMcReady),
  .awOutAddr(awOutAddr), .awOutId(awOutId),
  .errRValid(errRValid), .errRReady(errRReady), .errRLast(errRLast),
  .errWValid(errWValid), .errWReady(errWReady), .errWLast(errWLast),
  .errBValid(errBValid)
);

// File: tb/axiAliasRouter_test.sv
`timescale 1ns/1ps
module axiAliasRouter_test;

  localparam int ID_W  = 4;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootToMem = 1'b0;
  logic sArValid = 1'b0, sAwValid = 1'b0;
  logic [39:0] sArAddr = '0, sAwAddr = '0;
  logic [ID_W-1:0] sArId = '0, sAwId = '0;
  logic [LEN_W-1:0] sArLen = '0, sAwLen = '0;
  logic [2:0] sArSize = '0, sAwSize = '0, sArProt = '0, sAwProt = '0;
  logic [1:0] sArBurst = '0, sAwBurst = '0;
  logic arBrReady = 1'b0, arMcReady = 1'b0, awBrReady = 1'b0, awMcReady = 1'b0;
  logic errRReady = 1'b0, errBReady = 1'b0, errWValid = 1'b0, errWLast = 1'b0;

  logic sArReady, sAwReady, arBrValid, arMcValid, awBrValid, awMcValid;
  logic [39:0] arOutAddr, awOutAddr;
  logic [ID_W-1:0] arOutId, awOutId, errRId, errBId;
  logic [LEN_W-1:0] arOutLen, awOutLen;
  logic [2:0] arOutSize, awOutSize, arOutProt, awOutProt, arOutSection, awOutSection;
  logic [1:0] arOutBurst, awOutBurst, errRResp, errBResp;
  logic arOutProgIlv, awOutProgIlv, errRValid, errRLast, errWReady, errBValid;

  always #2.5 clk = ~clk;

  axiAliasRouter #(.ID_W(ID_W), .LEN_W(LEN_W)) uut (.*);

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
    nChecks++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // behavioural address map: route 0 bridge, 1 memory, 2 DECERR
  function automatic void refDecode(input logic [39:0] a, input bit boot, output int route,
                                    output logic [39:0] na, output int sec, output bit prog,
                                    output string tag);
    string order;
    int idx;
    order = "cdabghef";
    na = a; sec = 0; prog = 0;
    if (a >= 40'h04_0000_0000) begin route = 2; tag = "R1"; end
    else if (a >= 40'h01_0000_0000 && a < 40'h02_0000_0000) begin route = 2; tag = "R2"; end
    else if (a >= 40'h02_0000_0000) begin
      route = 1; tag = "R6";
      idx = int'((a - 40'h02_0000_0000) >> 30);
      sec = int'(order[idx]) - 97;
      prog = (sec < 2);
    end else if (a >= 40'h00_8000_0000) begin
      route = 1; tag = "R5";
      na = a + 40'h02_0000_0000;
      sec = (a >= 40'h00_C000_0000) ? 1 : 0;
      prog = 1;
    end else if (a < 40'h00_0010_0000) begin
      route = boot ? 1 : 0; tag = "R3";
    end else begin
      route = 0; tag = "R4";
    end
  endfunction

  // reference model state
  int arPh = 0, awPh = 0;   // ar: 0 idle 1 br 2 mc 3 err ; aw: 0 idle 1 br 2 mc 3 drain 4 resp
  int arBeats = 0;
  bit arStall = 0, awStall = 0;
  logic [39:0] arExpAddr, awExpAddr;
  int arSec, awSec;
  bit arProg, awProg;
  string arTag = "R10", awTag = "R10";
  logic [ID_W-1:0] arExpId, awExpId;
  logic [LEN_W-1:0] arExpLen, awExpLen;
  logic [2:0] arExpSize, awExpSize, arExpProt, awExpProt;
  logic [1:0] arExpBurst, awExpBurst;

  always @(posedge clk) begin
    int rt;
    if (!rstN) begin
      arPh = 0; awPh = 0; arStall = 0; awStall = 0;
    end else begin
      case (arPh)
        0: if (sArValid) begin
          refDecode(sArAddr, bootToMem, rt, arExpAddr, arSec, arProg, arTag);
          arExpId = sArId; arExpLen = sArLen; arExpSize = sArSize;
          arExpBurst = sArBurst; arExpProt = sArProt;
          arBeats = int'(sArLen) + 1;
          arPh = (rt == 0) ? 1 : (rt == 1) ? 2 : 3;
          arStall = 0;
        end
        1: begin arStall = !arBrReady; if (arBrReady) arPh = 0; end
        2: begin arStall = !arMcReady; if (arMcReady) arPh = 0; end
        3: if (errRReady) begin arBeats--; if (arBeats == 0) arPh = 0; end
        default: arPh = 0;
      endcase
      case (awPh)
        0: if (sAwValid) begin
          refDecode(sAwAddr, bootToMem, rt, awExpAddr, awSec, awProg, awTag);
          awExpId = sAwId; awExpLen = sAwLen; awExpSize = sAwSize;
          awExpBurst = sAwBurst; awExpProt = sAwProt;
          awPh = (rt == 0) ? 1 : (rt == 1) ? 2 : 3;
          awStall = 0;
        end
        1: begin awStall = !awBrReady; if (awBrReady) awPh = 0; end
        2: begin awStall = !awMcReady; if (awMcReady) awPh = 0; end
        3: if (errWValid && errWLast) awPh = 4;
        4: if (errBReady) awPh = 0;
        default: awPh = 0;
      endcase
    end
  end

  // compare one time unit after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rstN) begin
      chk("R12", "sArReady", sArReady, 1);
      chk("R12", "sAwReady", sAwReady, 1);
      chk("R12", "valids", {arBrValid, arMcValid, awBrValid, awMcValid, errRValid, errBValid, errWReady}, 0);
    end else begin
      string ta, tw;
      ta = (arPh == 0) ? "R10" : arTag;
      tw = (awPh == 0) ? "R10" : awTag;
      chk("R10", "sArReady", sArReady, arPh == 0);
      chk("R10", "sAwReady", sAwReady, awPh == 0);
      chk(ta, "arBrValid", arBrValid, arPh == 1);
      chk(ta, "arMcValid", arMcValid, arPh == 2);
      chk((arPh == 3) ? "R8" : ta, "errRValid", errRValid, arPh == 3);
      chk(tw, "awBrValid", awBrValid, awPh == 1);
      chk(tw, "awMcValid", awMcValid, awPh == 2);
      chk("R9", "errWReady", errWReady, awPh == 3);
      chk("R9", "errBValid", errBValid, awPh == 4);
      if (arPh == 1 || arPh == 2) begin
        chk(arStall ? "R11" : ta, "arOutAddr", arOutAddr, arExpAddr);
        chk(arStall ? "R11" : "R4", "ar attrs", {arOutId, arOutLen, arOutSize, arOutBurst, arOutProt},
            {arExpId, arExpLen, arExpSize, arExpBurst, arExpProt});
      end
      if (arPh == 2) begin
        chk((arTag == "R3") ? "R3" : "R6", "arOutSection", arOutSection, arSec);
        chk("R7", "arOutProgIlv", arOutProgIlv, arProg);
      end
      if (arPh == 3) begin
        chk("R8", "errRId", errRId, arExpId);
        chk("R8", "errRResp", errRResp, 2'b11);
        chk("R8", "errRLast", errRLast, arBeats == 1);
      end
      if (awPh == 1 || awPh == 2) begin
        chk(awStall ? "R11" : tw, "awOutAddr", awOutAddr, awExpAddr);
        chk(awStall ? "R11" : "R4", "aw attrs", {awOutId, awOutLen, awOutSize, awOutBurst, awOutProt},
            {awExpId, awExpLen, awExpSize, awExpBurst, awExpProt});
      end
      if (awPh == 2) begin
        chk((awTag == "R3") ? "R3" : "R6", "awOutSection", awOutSection, awSec);
        chk("R7", "awOutProgIlv", awOutProgIlv, awProg);
      end
      if (awPh == 4) begin
        chk("R9", "errBId", errBId, awExpId);
        chk("R9", "errBResp", errBResp, 2'b11);
      end
    end
  end

  // random back-pressure on every output
  always @(negedge clk) begin
    arBrReady <= ($urandom_range(0, 3) != 0);
    arMcReady <= ($urandom_range(0, 2) != 0);
    awBrReady <= ($urandom_range(0, 2) != 0);
    awMcReady <= ($urandom_range(0, 3) != 0);
    errRReady <= ($urandom_range(0, 3) != 0);
    errBReady <= ($urandom_range(0, 1) != 0);
  end

  task automatic sendAr(input logic [39:0] a, input int id, input int len);
    @(negedge clk);
    sArValid = 1; sArAddr = a; sArId = ID_W'(id); sArLen = LEN_W'(len);
    sArSize = 3'(id % 4); sArBurst = 2'b01; sArProt = 3'(id);
    while (!sArReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sArValid = 0;
  endtask

  task automatic sendAw(input logic [39:0] a, input int id, input int len);
    @(negedge clk);
    sAwValid = 1; sAwAddr = a; sAwId = ID_W'(id); sAwLen = LEN_W'(len);
    sAwSize = 3'(id % 3); sAwBurst = 2'b10; sAwProt = 3'(id + 1);
    while (!sAwReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sAwValid = 0;
  endtask

  task automatic sendW(input int n);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      errWValid = 1; errWLast = (b == n - 1);
      while (!errWReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    errWValid = 0; errWLast = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (arPh != 0 || awPh != 0) @(negedge clk);
  endtask

  task automatic finish();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=hung expected=idle");
    finish();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R4 bridge window and its edges
    sendAr(40'h00_0010_0000, 3, 2);
    sendAr(40'h00_7FFF_FFF0, 4, 0);
    sendAw(40'h00_4000_0000, 5, 7);
    settle();
    // R3 boot window in both modes
    sendAr(40'h00_000F_FFFF, 1, 0);
    settle();
    @(negedge clk); bootToMem = 1;
    sendAr(40'h00_0000_1000, 2, 3);
    sendAw(40'h00_000F_FFF0, 6, 1);
    settle();
    @(negedge clk); bootToMem = 0;
    // R5 low mirrors of sections a and b
    sendAr(40'h00_8000_1000, 7, 1);
    sendAw(40'h00_C123_4560, 8, 0);
    sendAr(40'h00_FFFF_FFFF, 9, 0);
    settle();
    // R6 / R7 every 1-GiB section of the memory span
    for (int i = 0; i < 8; i++) begin
      sendAw(40'h02_0000_0000 + (40'(i) << 30) + 40'h40, i, 1);
      sendAr(40'h02_3FFF_FF00 + (40'(i) << 30), i + 8, 2);
    end
    settle();
    // R2 hole, R8 read completion
    sendAr(40'h01_2000_0000, 5, 3);
    sendAr(40'h01_FFFF_FFFF, 6, 0);
    sendAw(40'h01_0000_0000, 7, 0);
    sendW(1);
    settle();
    // R1 upper reserved space, R9 write drain
    sendAw(40'h04_0000_0000, 9, 1);
    sendW(2);
    sendAr(40'hFF_FFFF_FFFF, 10, 0);
    settle();
    // R10 back-to-back requests on one channel
    sendAr(40'h00_2000_0000, 1, 0);
    sendAr(40'h03_4000_0000, 2, 0);
    sendAr(40'h05_0000_0000, 3, 2);
    settle();
    // concurrent DECERR read burst and DECERR write drain
    fork
      sendAr(40'h05_0000_0000, 11, 4);
      begin sendAw(40'h01_8000_0000, 12, 2); sendW(3); end
    join
    settle();
    fork
      sendAr(40'h01_0000_0040, 13, 2);
      sendAw(40'h00_9000_0000, 14, 0);
    join
    settle();
    repeat (5) @(posedge clk);
    finish();
  end

endmodule